// File: doc/BRIEF.md
# Byte ALU with Flag Registers

This block is the arithmetic core of a small byte-wide processor. It accepts two 8-bit operands and a 3-bit operation code, and it drives an 8-bit result combinationally. The operations are add, subtract, shift left, shift right, NAND and a pass-through. The pass-through forwards the second operand unchanged, so register moves and input-port transfers can reuse the ALU path.

Two flag registers sit beside the datapath: a zero flag and a negative flag. Both load on the rising clock edge, and only while the flag-load enable is high. The arithmetic and logic operations set the flags from the result. The shift operations are different: they place the bit shifted out into the zero flag and leave the negative flag alone.

A small controller steps through two named states. After reset it is in IDLE. The first clock edge after reset moves it to RUN (transition WAKE), and it stays in RUN until the next reset (transition HOLD). Flag updates are accepted only in RUN. This means the flags keep their reset value of zero for the first cycle after reset.

Top module: `byte_alu`

## Requirements
- R1: The result is combinational. Mode 3'b100 gives the sum a+b modulo 256. Mode 3'b101 gives a-b in two's complement (0xFF-0x18 = 0xE7).
- R2: Mode 3'b001 gives the bitwise NAND ~(a&b).
- R3: Mode 3'b110 gives {a[6:0],1'b0}. Mode 3'b111 gives {1'b0,a[7:1]}.
- R4: Modes 3'b000, 3'b010 and 3'b011 pass operand b to the result unchanged.
- R5: When the flags load after add, subtract or NAND, z_flag becomes 1 exactly when the 8-bit result is zero, and n_flag takes result bit 7.
- R6: When the flags load after shift left, z_flag takes the old a[7]. After shift right it takes the old a[0]. A shift leaves n_flag unchanged.
- R7: When the flags load in a pass-through mode, both flags hold their values. When flag_ld is low, both flags hold their values in every mode.
- R8: A synchronous active-high reset clears both flags and puts the controller in IDLE. In IDLE, flag_ld is ignored. The controller moves to RUN on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 8 | First operand; the only operand of the shifts |
| op_b | input | 8 | Second operand; the pass-through source |
| mode | input | 3 | Operation select |
| flag_ld | input | 1 | Enables the flag update at the next edge |
| result | output | 8 | Combinational result |
| z_flag | output | 1 | Registered zero flag (bit shifted out for shifts) |
| n_flag | output | 1 | Registered negative flag |

## Verification
The assertions check on every cycle the rules that follow from one clock edge: flags hold when the load is disabled or the mode is pass-through, a shift leaves the negative flag alone, reset clears both flags, and the zero flag agrees with a zero result for the arithmetic modes. Only the bench scenarios can show that each mode's result value is correct and that the two's complement wrap is right. The same holds for which bit each shift drops into the zero flag, and for the IDLE cycle that follows reset.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
    typedef enum logic [2:0] {
        MD_PASS = 3'b000,
        MD_NAND = 3'b001,
        MD_PAS2 = 3'b010,
        MD_PAS3 = 3'b011,
        MD_ADD  = 3'b100,
        MD_SUB  = 3'b101,
        MD_SHL  = 3'b110,
        MD_SHR  = 3'b111
    } alu_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_e;

    typedef enum logic [1:0] {
        FK_HOLD  = 2'd0,
        FK_TEST  = 2'd1,
        FK_SHIFT = 2'd2
    } flag_kind_e;
endpackage

// File: rtl/byte_alu_core.sv
module byte_alu_core
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_mode_e    md,
    output logic [W-1:0] y,
    output flag_kind_e   kind,
    output logic         shift_bit
);
    localparam int MSB = W - 1;

    always_comb begin
        y         = b;
        kind      = FK_HOLD;
        shift_bit = 1'b0;
        unique case (md)
            MD_ADD: begin y = a + b;    kind = FK_TEST; end
            MD_SUB: begin y = a - b;    kind = FK_TEST; end
            MD_NAND: begin y = ~(a & b); kind = FK_TEST; end
            MD_SHL: begin
                y = {a[MSB-1:0], 1'b0};
                kind = FK_SHIFT;
                shift_bit = a[MSB];
            end
            MD_SHR: begin
                y = {1'b0, a[MSB:1]};
                kind = FK_SHIFT;
                shift_bit = a[0];
            end
            MD_PASS, MD_PAS2, MD_PAS3: begin
                y = b;
                kind = FK_HOLD;
            end
            default: y = b;
        endcase
    end
endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  flag_kind_e   kind,
    input  logic [W-1:0] y,
    input  logic         shift_bit,
    output logic         z_q,
    output logic         n_q
);
    ctl_state_e st_q, st_d;
    logic       upd;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // next state and output decode
    always_comb begin
        st_d = st_q;
        upd  = 1'b0;
        unique case (st_q)
            ST_IDLE: st_d = ST_RUN;            // WAKE
            ST_RUN: begin
                st_d = ST_RUN;                 // HOLD
                upd  = load;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            z_q <= 1'b0;
            n_q <= 1'b0;
        end else if (upd) begin
            unique case (kind)
                FK_TEST: begin
                    z_q <= (y == '0);
                    n_q <= y[W-1];
                end
                FK_SHIFT: z_q <= shift_bit;
                default: ;
            endcase
        end
    end

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(z_q) && $stable(n_q));
    // R6
    shift_keeps_n_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == FK_SHIFT) |=> $stable(n_q));
    // R8
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> !z_q && !n_q);
    // R5
    zero_matches_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && kind == FK_TEST && y == '0) |=> z_q && !n_q);
    // R7
    pass_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == FK_HOLD) |=> $stable(z_q) && $stable(n_q));
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [2:0]   mode,
    input  logic         flag_ld,
    output logic [W-1:0] result,
    output logic         z_flag,
    output logic         n_flag
);
    flag_kind_e kind_w;
    logic       sbit_w;

    byte_alu_core #(.W(W)) u_core (
        .a(op_a), .b(op_b), .md(alu_mode_e'(mode)),
        .y(result), .kind(kind_w), .shift_bit(sbit_w)
    );

    byte_alu_flags #(.W(W)) u_flags (
        .clk(clk), .rst(rst), .load(flag_ld), .kind(kind_w),
        .y(result), .shift_bit(sbit_w), .z_q(z_flag), .n_q(n_flag)
    );

    // R4
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b000) |-> result == op_b);
endmodule

// File: tb/byte_alu_test.sv
module byte_alu_test;
    logic       clk = 0, rst = 1;
    logic [7:0] op_a = 0, op_b = 0;
    logic [2:0] mode = 0;
    logic       flag_ld = 0;
    logic [7:0] result;
    logic       z_flag, n_flag;
    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    byte_alu uut (.clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .mode(mode),
                  .flag_ld(flag_ld), .result(result), .z_flag(z_flag), .n_flag(n_flag));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // apply inputs at negedge, clock one edge, sample at next negedge
    task automatic op(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b, input logic ld);
        @(negedge clk);
        mode = m; op_a = a; op_b = b; flag_ld = ld;
        @(negedge clk);
        flag_ld = 0;
    endtask

    task automatic t_reset();
        rst = 1; flag_ld = 1; mode = 3'b101; op_a = 8'h00; op_b = 8'h01;
        @(negedge clk); @(negedge clk);
        chk("R8 z after reset", z_flag, 0);
        chk("R8 n after reset", n_flag, 0);
        rst = 0;               // next edge: IDLE->RUN, load ignored
        @(negedge clk);
        chk("R8 idle ignores load n", n_flag, 0);
        flag_ld = 0;
    endtask

    task automatic t_arith();
        op(3'b101, 8'hFF, 8'h18, 1);
        chk("R1 sub result", result, 8'hE7);
        chk("R5 sub n", n_flag, 1);
        chk("R5 sub z", z_flag, 0);
        op(3'b100, 8'hC0, 8'h03, 0);
        chk("R1 add result", result, 8'hC3);
        chk("R7 no load keeps n", n_flag, 1);
        op(3'b100, 8'h80, 8'h80, 1);
        chk("R1 add wrap", result, 8'h00);
        chk("R5 add zero z", z_flag, 1);
        chk("R5 add zero n", n_flag, 0);
    endtask

    task automatic t_nand();
        op(3'b001, 8'hC3, 8'hFF, 1);
        chk("R2 nand result", result, 8'h3C);
        chk("R5 nand z", z_flag, 0);
        chk("R5 nand n", n_flag, 0);
        op(3'b001, 8'hFF, 8'hFF, 1);
        chk("R5 nand zero z", z_flag, 1);
    endtask

    task automatic t_shift();
        op(3'b101, 8'h00, 8'h01, 1);    // z=0 n=1
        op(3'b110, 8'h81, 8'h00, 1);
        chk("R3 shl result", result, 8'h02);
        chk("R6 shl z old bit7", z_flag, 1);
        chk("R6 shl keeps n", n_flag, 1);
        op(3'b111, 8'hC2, 8'h00, 1);
        chk("R3 shr result", result, 8'h61);
        chk("R6 shr z old bit0", z_flag, 0);
        op(3'b111, 8'h01, 8'h00, 1);
        chk("R6 shr z set", z_flag, 1);
        chk("R6 shr keeps n", n_flag, 1);
    endtask

    task automatic t_pass();
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            op(m[2:0], 8'h55, 8'hA0 + 8'(m), 1);
            chk("R4 pass result", result, 8'hA0 + m);
            chk("R7 pass holds z", z_flag, 1);
            chk("R7 pass holds n", n_flag, 1);
        end
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_arith();
                t_nand();
                t_shift();
                t_pass();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule